// File: doc/BRIEF.md
# Pulse-Gap Tag Write Encoder

This block drives the field-enable line of a low-frequency reader while it programs a tag. A start request loads a 64-bit payload and a 16-bit checksum. The block then keeps the field on for a charge interval so the tag can power up. Next it sends a fixed frame of fourteen bytes. After the last bit it keeps the field on for a programming interval, switches the field off, and reports completion.

Every bit takes the same time. A bit is a field-off gap followed by field-on time that fills the rest of the bit period. A long gap means a one and a short gap means a zero. All timing is counted in microseconds. A tick divider derives the microsecond tick from the system clock and restarts on each accepted start, so every interval is an exact number of clock cycles.

The frame has fourteen bytes in this order:
- a keyword byte 0xBB;
- a password byte 0xEB;
- eight payload bytes, least significant byte first;
- the checksum, low byte first;
- the trailer bytes 0x00 and then 0x03.

Each byte is sent least significant bit first. Default timing:
- bit period 2000 us;
- gap of 1000 us for a one and 300 us for a zero;
- 50000 us charge and 50000 us programming wait.

All of these timings are parameters.

Top module: `tag_write_encoder`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `field_on_o`, `busy_o` and `done_o` are all low.
- R2: A `start_i` pulse seen in idle makes `busy_o` high from the next clock edge. The field is then on for exactly CHARGE_US × CLKS_PER_US cycles before the first gap.
- R3: A one bit is the field off for ONE_OFF_US × CLKS_PER_US cycles, then on for (BIT_US − ONE_OFF_US) × CLKS_PER_US cycles.
- R4: A zero bit is the field off for ZERO_OFF_US × CLKS_PER_US cycles, then on for (BIT_US − ZERO_OFF_US) × CLKS_PER_US cycles.
- R5: The frame holds 112 bits in 14 bytes, in this order:
  - 0xBB, then 0xEB;
  - `data_i[7:0]` up to `data_i[63:56]`;
  - `crc_i[7:0]`, then `crc_i[15:8]`;
  - 0x00, then 0x03.
- R6: Within each byte, bit 0 is sent first and bit 7 last.
- R7: After the last bit the field stays on for PROG_US × CLKS_PER_US cycles. On the next edge the field goes off, `busy_o` falls and `done_o` is high for exactly one cycle.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The frame in progress is unchanged, and no second frame follows it.
- R9: Asserting reset during a frame forces the field off and returns the block to idle. A later start runs a complete frame.
- R10: `data_i` and `crc_i` are captured when a start is accepted. Changing them during a frame has no effect on the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to send one write frame |
| data_i | input | 64 | Payload, byte 0 in bits 7:0 |
| crc_i | input | 16 | Checksum, low byte in bits 7:0 |
| field_on_o | output | 1 | High enables the reader field |
| busy_o | output | 1 | High while a frame is in progress |
| done_o | output | 1 | One-cycle pulse at the end of the programming wait |

## Verification
The embedded assertions check these properties on every cycle:
- the field is off whenever the sequencer is idle;
- the field is off during a gap and on in every other active phase;
- the payload register holds still while a frame runs;
- the charge phase is only entered from idle;
- the completion pulse is a single cycle that follows the programming phase;
- the tick divider and the byte pointer stay in range.

Other properties need the bench's scenarios:
- the exact lengths of the charge, gap, mark and programming intervals;
- the byte order and bit order of the frame;
- the loss of a start request made while busy;
- recovery after a reset in the middle of a frame.

The bench compares the field line cycle by cycle against a waveform it computes from the payload.

// File: rtl/tag_write_pkg.sv
package tag_write_pkg;

    localparam int TW_DATA_BYTES  = 8;
    localparam int TW_CRC_BYTES   = 2;
    localparam int TW_FRAME_BYTES = 2 + TW_DATA_BYTES + TW_CRC_BYTES + 2;
    localparam int TW_IDX_W       = $clog2(TW_FRAME_BYTES);
    localparam int TW_DATA_W      = TW_DATA_BYTES * 8;
    localparam int TW_CRC_W       = TW_CRC_BYTES * 8;

    localparam logic [7:0] TW_KEYWORD    = 8'hBB;
    localparam logic [7:0] TW_PASSWORD   = 8'hEB;
    localparam logic [7:0] TW_TRAILER_LO = 8'h00;
    localparam logic [7:0] TW_TRAILER_HI = 8'h03;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHARGE,
        ST_GAP,
        ST_MARK,
        ST_PROG
    } tw_state_e;

endpackage

// File: rtl/us_tick_gen.sv
module us_tick_gen #(
    parameter int CLKS_PER_US = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic tick_o
);
    localparam int CW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_US - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R2
    divider_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/frame_byte_sel.sv
module frame_byte_sel
    import tag_write_pkg::*;
(
    input  logic [TW_DATA_W-1:0] data_i,
    input  logic [TW_CRC_W-1:0]  crc_i,
    input  logic [TW_IDX_W-1:0]  idx_i,
    output logic [7:0]           byte_o
);
    logic [7:0] frame_tbl [TW_FRAME_BYTES];

    assign frame_tbl[0] = TW_KEYWORD;
    assign frame_tbl[1] = TW_PASSWORD;

    for (genvar g = 0; g < TW_DATA_BYTES; g++) begin : g_data
        assign frame_tbl[2 + g] = data_i[8*g +: 8];
    end

    for (genvar c = 0; c < TW_CRC_BYTES; c++) begin : g_crc
        assign frame_tbl[2 + TW_DATA_BYTES + c] = crc_i[8*c +: 8];
    end

    assign frame_tbl[TW_FRAME_BYTES-2] = TW_TRAILER_LO;
    assign frame_tbl[TW_FRAME_BYTES-1] = TW_TRAILER_HI;

    always_comb begin
        byte_o = '0;
        for (int i = 0; i < TW_FRAME_BYTES; i++) begin
            if (idx_i == TW_IDX_W'(i)) begin
                byte_o = frame_tbl[i];
            end
        end
    end

endmodule

// File: rtl/tag_write_encoder.sv
module tag_write_encoder
    import tag_write_pkg::*;
#(
    parameter int CLKS_PER_US = 100,
    parameter int CHARGE_US   = 50000,
    parameter int BIT_US      = 2000,
    parameter int ONE_OFF_US  = 1000,
    parameter int ZERO_OFF_US = 300,
    parameter int PROG_US     = 50000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [63:0] data_i,
    input  logic [15:0] crc_i,
    output logic        field_on_o,
    output logic        busy_o,
    output logic        done_o
);
    localparam int MAX_A  = (CHARGE_US > PROG_US) ? CHARGE_US : PROG_US;
    localparam int MAX_US = (MAX_A > BIT_US) ? MAX_A : BIT_US;
    localparam int UW     = $clog2(MAX_US + 1);

    localparam logic [UW-1:0] CHARGE_LAST   = UW'(CHARGE_US - 1);
    localparam logic [UW-1:0] BIT_LAST      = UW'(BIT_US - 1);
    localparam logic [UW-1:0] ONE_OFF_LAST  = UW'(ONE_OFF_US - 1);
    localparam logic [UW-1:0] ZERO_OFF_LAST = UW'(ZERO_OFF_US - 1);
    localparam logic [UW-1:0] PROG_LAST     = UW'(PROG_US - 1);
    localparam logic [TW_IDX_W-1:0] LAST_BYTE = TW_IDX_W'(TW_FRAME_BYTES - 1);

    typedef struct packed {
        tw_state_e             st;
        logic [UW-1:0]         us_cnt;
        logic [TW_IDX_W-1:0]   byte_idx;
        logic [2:0]            bit_idx;
        logic [TW_DATA_W-1:0]  data;
        logic [TW_CRC_W-1:0]   crc;
        logic                  field;
        logic                  done;
    } tw_regs_t;

    tw_regs_t   r_d, r_q;
    logic       tick;
    logic       tick_clear;
    logic [7:0] cur_byte;
    logic       cur_bit;
    logic [UW-1:0] gap_last;

    us_tick_gen #(
        .CLKS_PER_US(CLKS_PER_US)
    ) i_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(tick_clear),
        .tick_o (tick)
    );

    frame_byte_sel i_sel (
        .data_i(r_q.data),
        .crc_i (r_q.crc),
        .idx_i (r_q.byte_idx),
        .byte_o(cur_byte)
    );

    assign cur_bit  = cur_byte[r_q.bit_idx];
    assign gap_last = cur_bit ? ONE_OFF_LAST : ZERO_OFF_LAST;

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        tick_clear = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.field = 1'b0;
                if (start_i) begin
                    r_d.st       = ST_CHARGE;
                    r_d.data     = data_i;
                    r_d.crc      = crc_i;
                    r_d.field    = 1'b1;
                    r_d.us_cnt   = '0;
                    r_d.byte_idx = '0;
                    r_d.bit_idx  = '0;
                    tick_clear   = 1'b1;
                end
            end
            ST_CHARGE: begin
                if (tick) begin
                    if (r_q.us_cnt == CHARGE_LAST) begin
                        r_d.st     = ST_GAP;
                        r_d.field  = 1'b0;
                        r_d.us_cnt = '0;
                    end else begin
                        r_d.us_cnt = r_q.us_cnt + 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    r_d.us_cnt = r_q.us_cnt + 1'b1;
                    if (r_q.us_cnt == gap_last) begin
                        r_d.st    = ST_MARK;
                        r_d.field = 1'b1;
                    end
                end
            end
            ST_MARK: begin
                if (tick) begin
                    if (r_q.us_cnt == BIT_LAST) begin
                        r_d.us_cnt = '0;
                        if (r_q.byte_idx == LAST_BYTE && r_q.bit_idx == 3'd7) begin
                            r_d.st = ST_PROG;
                        end else begin
                            r_d.st      = ST_GAP;
                            r_d.field   = 1'b0;
                            r_d.bit_idx = r_q.bit_idx + 1'b1;
                            if (r_q.bit_idx == 3'd7) begin
                                r_d.byte_idx = r_q.byte_idx + 1'b1;
                            end
                        end
                    end else begin
                        r_d.us_cnt = r_q.us_cnt + 1'b1;
                    end
                end
            end
            ST_PROG: begin
                if (tick) begin
                    if (r_q.us_cnt == PROG_LAST) begin
                        r_d.st     = ST_IDLE;
                        r_d.field  = 1'b0;
                        r_d.done   = 1'b1;
                        r_d.us_cnt = '0;
                    end else begin
                        r_d.us_cnt = r_q.us_cnt + 1'b1;
                    end
                end
            end
            default: begin
                r_d       = r_q;
                r_d.st    = ST_IDLE;
                r_d.field = 1'b0;
                r_d.done  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign field_on_o = r_q.field;
    assign busy_o     = (r_q.st != ST_IDLE);
    assign done_o     = r_q.done;

    // R1 / R9
    idle_field_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> !field_on_o);

    // R3 / R4
    gap_field_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_GAP) |-> !field_on_o);

    // R2 / R7
    active_field_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CHARGE || r_q.st == ST_MARK || r_q.st == ST_PROG) |-> field_on_o);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_after_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(r_q.st) == ST_PROG && !busy_o));

    // R8
    charge_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CHARGE && $past(r_q.st) != ST_CHARGE) |-> ($past(r_q.st) == ST_IDLE));

    // R10
    payload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(r_q.data) && $stable(r_q.crc)));

    // R5
    byte_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.byte_idx <= LAST_BYTE);

endmodule

// File: tb/test_tag_write_encoder.sv
module test_tag_write_encoder;

    localparam int K     = 2;
    localparam int CH    = 20;
    localparam int BITP  = 10;
    localparam int ONE   = 5;
    localparam int ZERO  = 2;
    localparam int PROG  = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] data_i = '0;
    logic [15:0] crc_i = '0;
    logic        field_on_o, busy_o, done_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    tag_write_encoder #(
        .CLKS_PER_US(K), .CHARGE_US(CH), .BIT_US(BITP),
        .ONE_OFF_US(ONE), .ZERO_OFF_US(ZERO), .PROG_US(PROG)
    ) i_tag_write_encoder (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .data_i(data_i), .crc_i(crc_i),
        .field_on_o(field_on_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int i, input logic [63:0] d, input logic [15:0] c);
        case (i)
            0:  return 8'hBB;
            1:  return 8'hEB;
            10: return c[7:0];
            11: return c[15:8];
            12: return 8'h00;
            13: return 8'h03;
            default: return d[(i-2)*8 +: 8];
        endcase
    endfunction

    // Checks one segment of constant expected level, starting at the current negedge.
    task automatic check_seg(input logic level, input int ncyc, input string tag, input bit poke);
        int bad = 0;
        int first_act = 0;
        for (int j = 0; j < ncyc; j++) begin
            if (poke && j == 0) begin
                start_i = 1'b1;
                data_i  = ~data_i;
                crc_i   = ~crc_i;
            end
            if (poke && j == 1) start_i = 1'b0;
            if (field_on_o !== level || busy_o !== 1'b1 || done_o !== 1'b0) begin
                if (bad == 0) first_act = int'(field_on_o);
                bad++;
            end
            @(negedge clk);
        end
        check(bad == 0, tag, first_act, int'(level));
    endtask

    task automatic run_frame(input logic [63:0] d, input logic [15:0] c, input bit poke);
        @(negedge clk);
        data_i  = d;
        crc_i   = c;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check_seg(1'b1, CH * K, "R2 charge", 1'b0);
        for (int b = 0; b < 112; b++) begin
            logic [7:0] eb = exp_byte(b / 8, d, c);
            logic       bv = eb[b % 8];
            int         off = bv ? ONE : ZERO;
            check_seg(1'b0, off * K, bv ? "R3 one gap (R5 R6 order, R10)" : "R4 zero gap (R5 R6 order, R10)",
                      poke && b == 40);
            check_seg(1'b1, (BITP - off) * K, bv ? "R3 one mark" : "R4 zero mark", 1'b0);
        end
        check_seg(1'b1, PROG * K, "R7 programming wait", 1'b0);
        check(field_on_o == 1'b0 && busy_o == 1'b0 && done_o == 1'b1, "R7 end of frame",
              {field_on_o, busy_o, done_o}, 3'b001);
        @(negedge clk);
        check(done_o == 1'b0, "R7 done single cycle", int'(done_o), 0);
        begin
            int stray = 0;
            for (int j = 0; j < 20; j++) begin
                if (busy_o || field_on_o) stray++;
                @(negedge clk);
            end
            check(stray == 0, poke ? "R8 no second frame" : "R7 stays idle", stray, 0);
        end
    endtask

    initial begin
        #(150000 * 4);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #1;
        check(field_on_o == 0 && busy_o == 0 && done_o == 0, "R1 in reset",
              {field_on_o, busy_o, done_o}, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(field_on_o == 0 && busy_o == 0 && done_o == 0, "R1 after reset",
              {field_on_o, busy_o, done_o}, 0);

        run_frame(64'h0, 16'h0, 1'b0);
        run_frame(64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF, 1'b0);
        run_frame(64'h0123_4567_89AB_CDEF, 16'hA55A, 1'b0);
        run_frame(64'h8000_0000_0000_0001, 16'h8001, 1'b1);
        for (int g = 0; g < 8; g++) begin
            run_frame(64'h1 << (8 * g + g), 16'h1 << (2 * g), 1'b0);
        end

        // R9: reset in the middle of a frame
        @(negedge clk);
        data_i = 64'hDEAD_BEEF_0BAD_F00D;
        crc_i = 16'h1234;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (CH * K + 150) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(field_on_o == 0 && busy_o == 0, "R9 reset mid-frame", {field_on_o, busy_o}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(busy_o == 0 && field_on_o == 0, "R9 idle after reset", {field_on_o, busy_o}, 0);
        run_frame(64'hDEAD_BEEF_0BAD_F00D, 16'h1234, 1'b0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule